// File: doc/BRIEF.md
# VLAN Membership Resolution Table

This block is the VLAN stage of a switch's forwarding path. It holds up to 32 VLAN entries. Each entry stores a 12-bit VLAN ID, a valid flag, a port membership bitmap and a per-port untagged bitmap. A host write port fills these entries. The same write port sets two control bits for each port: one that drops frames from non-members, and one that bounds flooding by VLAN membership.

The forwarding address lookup ignores the VLAN ID, so this table is the only per-VLAN forwarding control in the switch. A lookup carries an ingress port number, a VID and the default flood set that the address stage supplies. One clock later the block returns a valid strobe together with:
- hit or miss,
- an accept or discard decision,
- the destination port mask, which never contains the ingress port,
- the bitmap of egress ports on which the egress logic must strip the tag.

In every bitmap, bit p stands for port p. Host software must make each port a member of the entry that holds that port's default VID. The block does not enforce this.

Top module: `vlan_resolve`

## Requirements
- R1: A write with `wr_en_i`=1 and `wr_kind_i`=0 loads entry `wr_idx_i` (0..31) with `wr_vid_i`, `wr_valid_i`, `wr_member_i` and `wr_untag_i`. A lookup requested in any later cycle sees the new contents. A lookup requested in the same cycle as the write sees the previous contents.
- R2: `lk_valid_o` is 1 exactly in the cycle after a cycle with `lk_req_i`=1, and it is 0 otherwise. The result fields belong to that request.
- R3: An entry matches only when its valid flag is 1, its VID is nonzero and its VID equals `lk_vid_i`. `lk_hit_o` is 1 exactly when some entry matches.
- R4: When several entries match, the entry with the lowest index supplies the membership and untagged bitmaps.
- R5: A write with `wr_kind_i`=1 sets the discard bit and the verify bit of port `wr_idx_i` from `wr_discard_i` and `wr_verify_i`. When the discard bit of the ingress port is 1 and that port is not a member of the matching entry, or there is no match, `lk_accept_o`=0 and `lk_mask_o`=0. In all other cases `lk_accept_o`=1.
- R6: For an accepted lookup whose ingress port has the verify bit set, the mask is the matching entry's membership bitmap, or empty on a miss.
- R7: For an accepted lookup whose ingress port has the verify bit clear, the mask is `dflt_flood_i`.
- R8: The bit of the ingress port is always 0 in `lk_mask_o`.
- R9: On a hit, `lk_untag_o` is the matching entry's untagged bitmap ANDed with its membership bitmap. On a miss it is 0.
- R10: After reset all entries are invalid, all discard and verify bits are clear and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_kind_i | input | 1 | Write target: 0 = entry, 1 = port control |
| wr_idx_i | input | 5 | Entry index, or port number for a port-control write |
| wr_vid_i | input | 12 | VID to store in the entry |
| wr_valid_i | input | 1 | Valid flag to store in the entry |
| wr_member_i | input | 4 | Membership bitmap to store in the entry |
| wr_untag_i | input | 4 | Untagged bitmap to store in the entry |
| wr_discard_i | input | 1 | Discard bit for the port |
| wr_verify_i | input | 1 | Verify bit for the port |
| lk_req_i | input | 1 | Lookup request |
| lk_port_i | input | 2 | Ingress port of the lookup |
| lk_vid_i | input | 12 | VID of the frame |
| dflt_flood_i | input | 4 | Default flood set for the lookup |
| lk_valid_o | output | 1 | Result strobe, one cycle after the request |
| lk_hit_o | output | 1 | A valid entry matched |
| lk_accept_o | output | 1 | 1 = forward, 0 = discard |
| lk_mask_o | output | 4 | Destination port mask |
| lk_untag_o | output | 4 | Egress ports that must strip the tag |

## Verification
Every result is due one clock after its request. The bench drives inputs on the falling edge. At the next falling edge it compares the outputs with the values it computed from its own copy of the table. It takes that copy as it stood before any write issued in the request cycle, which is the only table state the request may see. A write is applied to the bench's copy in the cycle it is driven, so a lookup one cycle later must already see it. This covers the same-cycle and next-cycle cases of R1 directly. In cycles without a request the bench checks that `lk_valid_o` is low.

// File: rtl/vlan_res_pkg.sv
package vlan_res_pkg;
  localparam int VID_W = 12;
  typedef enum logic {WR_ENTRY = 1'b0, WR_PORT = 1'b1} wr_kind_e;
endpackage

// File: rtl/vlan_res_table.sv
module vlan_res_table
  import vlan_res_pkg::*;
#(
  parameter int N_ENTRY = 32,
  parameter int N_PORT  = 4,
  parameter int IDX_W   = $clog2(N_ENTRY)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic                             wr_kind_i,
  input  logic [IDX_W-1:0]                 wr_idx_i,
  input  logic [VID_W-1:0]                 wr_vid_i,
  input  logic                             wr_valid_i,
  input  logic [N_PORT-1:0]                wr_member_i,
  input  logic [N_PORT-1:0]                wr_untag_i,
  input  logic                             wr_discard_i,
  input  logic                             wr_verify_i,
  output logic [N_ENTRY-1:0]               ent_valid_o,
  output logic [N_ENTRY-1:0][VID_W-1:0]    ent_vid_o,
  output logic [N_ENTRY-1:0][N_PORT-1:0]   ent_member_o,
  output logic [N_ENTRY-1:0][N_PORT-1:0]   ent_untag_o,
  output logic [N_PORT-1:0]                discard_o,
  output logic [N_PORT-1:0]                verify_o
);
  logic ent_wr, port_wr;
  assign ent_wr  = wr_en_i && (wr_kind_i == WR_ENTRY);
  assign port_wr = wr_en_i && (wr_kind_i == WR_PORT);

  for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_valid_o[e]  <= 1'b0;
        ent_vid_o[e]    <= '0;
        ent_member_o[e] <= '0;
        ent_untag_o[e]  <= '0;
      end else if (ent_wr && wr_idx_i == IDX_W'(e)) begin
        ent_valid_o[e]  <= wr_valid_i;
        ent_vid_o[e]    <= wr_vid_i;
        ent_member_o[e] <= wr_member_i;
        ent_untag_o[e]  <= wr_untag_i;
      end
    end
  end

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        discard_o[p] <= 1'b0;
        verify_o[p]  <= 1'b0;
      end else if (port_wr && wr_idx_i == IDX_W'(p)) begin
        discard_o[p] <= wr_discard_i;
        verify_o[p]  <= wr_verify_i;
      end
    end
  end
endmodule

// File: rtl/vlan_res_match.sv
module vlan_res_match
  import vlan_res_pkg::*;
#(
  parameter int N_ENTRY = 32,
  parameter int IDX_W   = $clog2(N_ENTRY)
) (
  input  logic [N_ENTRY-1:0]            ent_valid_i,
  input  logic [N_ENTRY-1:0][VID_W-1:0] ent_vid_i,
  input  logic [VID_W-1:0]              lk_vid_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              sel_o
);
  logic [N_ENTRY-1:0] hv;

  for (genvar e = 0; e < N_ENTRY; e++) begin : g_cmp
    // VID 0 is reserved and never resolves
    assign hv[e] = ent_valid_i[e] && (ent_vid_i[e] != '0) && (ent_vid_i[e] == lk_vid_i);
  end

  always_comb begin
    sel_o = '0;
    for (int i = N_ENTRY - 1; i >= 0; i--) begin
      if (hv[i]) sel_o = IDX_W'(i);
    end
  end

  assign hit_o = |hv;
endmodule

// File: rtl/vlan_res_decide.sv
module vlan_res_decide #(
  parameter int N_PORT = 4,
  parameter int PORT_W = $clog2(N_PORT)
) (
  input  logic              hit_i,
  input  logic [N_PORT-1:0] member_i,
  input  logic [N_PORT-1:0] untag_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [N_PORT-1:0] discard_i,
  input  logic [N_PORT-1:0] verify_i,
  input  logic [N_PORT-1:0] dflt_i,
  output logic              accept_o,
  output logic [N_PORT-1:0] mask_o,
  output logic [N_PORT-1:0] untag_o
);
  logic              in_member, accept;
  logic [N_PORT-1:0] base;

  always_comb begin
    in_member = hit_i && member_i[port_i];
    accept    = !(discard_i[port_i] && !in_member);
    if (!accept)                base = '0;
    else if (verify_i[port_i])  base = hit_i ? member_i : '0;
    else                        base = dflt_i;
    mask_o   = base & ~(N_PORT'(1) << port_i);
    untag_o  = hit_i ? (untag_i & member_i) : '0;
    accept_o = accept;
  end
endmodule

// File: rtl/vlan_resolve.sv
module vlan_resolve
  import vlan_res_pkg::*;
#(
  parameter int N_ENTRY = 32,
  parameter int N_PORT  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic                         wr_kind_i,
  input  logic [$clog2(N_ENTRY)-1:0]   wr_idx_i,
  input  logic [VID_W-1:0]             wr_vid_i,
  input  logic                         wr_valid_i,
  input  logic [N_PORT-1:0]            wr_member_i,
  input  logic [N_PORT-1:0]            wr_untag_i,
  input  logic                         wr_discard_i,
  input  logic                         wr_verify_i,
  input  logic                         lk_req_i,
  input  logic [$clog2(N_PORT)-1:0]    lk_port_i,
  input  logic [VID_W-1:0]             lk_vid_i,
  input  logic [N_PORT-1:0]            dflt_flood_i,
  output logic                         lk_valid_o,
  output logic                         lk_hit_o,
  output logic                         lk_accept_o,
  output logic [N_PORT-1:0]            lk_mask_o,
  output logic [N_PORT-1:0]            lk_untag_o
);
  localparam int IDX_W  = $clog2(N_ENTRY);
  localparam int PORT_W = $clog2(N_PORT);

  logic [N_ENTRY-1:0]              ent_valid;
  logic [N_ENTRY-1:0][VID_W-1:0]   ent_vid;
  logic [N_ENTRY-1:0][N_PORT-1:0]  ent_member, ent_untag;
  logic [N_PORT-1:0]               discard, verify;
  logic                            hit, accept;
  logic [IDX_W-1:0]                sel;
  logic [N_PORT-1:0]               mask, untag;

  vlan_res_table #(.N_ENTRY(N_ENTRY), .N_PORT(N_PORT), .IDX_W(IDX_W)) u_table (
    .clk_i, .rst_ni, .wr_en_i, .wr_kind_i, .wr_idx_i, .wr_vid_i, .wr_valid_i,
    .wr_member_i, .wr_untag_i, .wr_discard_i, .wr_verify_i,
    .ent_valid_o(ent_valid), .ent_vid_o(ent_vid), .ent_member_o(ent_member),
    .ent_untag_o(ent_untag), .discard_o(discard), .verify_o(verify)
  );

  vlan_res_match #(.N_ENTRY(N_ENTRY), .IDX_W(IDX_W)) u_match (
    .ent_valid_i(ent_valid), .ent_vid_i(ent_vid), .lk_vid_i,
    .hit_o(hit), .sel_o(sel)
  );

  vlan_res_decide #(.N_PORT(N_PORT), .PORT_W(PORT_W)) u_decide (
    .hit_i(hit), .member_i(ent_member[sel]), .untag_i(ent_untag[sel]),
    .port_i(lk_port_i), .discard_i(discard), .verify_i(verify),
    .dflt_i(dflt_flood_i), .accept_o(accept), .mask_o(mask), .untag_o(untag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o  <= 1'b0;
      lk_hit_o    <= 1'b0;
      lk_accept_o <= 1'b0;
      lk_mask_o   <= '0;
      lk_untag_o  <= '0;
    end else begin
      lk_valid_o <= lk_req_i;
      if (lk_req_i) begin
        lk_hit_o    <= hit;
        lk_accept_o <= accept;
        lk_mask_o   <= mask;
        lk_untag_o  <= untag;
      end
    end
  end
endmodule

// File: rtl/vlan_resolve_chk.sv
module vlan_resolve_chk #(
  parameter int N_PORT = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      lk_req_i,
  input logic [$clog2(N_PORT)-1:0] lk_port_i,
  input logic                      lk_valid_o,
  input logic                      lk_hit_o,
  input logic                      lk_accept_o,
  input logic [N_PORT-1:0]         lk_mask_o,
  input logic [N_PORT-1:0]         lk_untag_o
);
  // R2
  valid_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> lk_valid_o);
  // R2
  valid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |=> !lk_valid_o);
  // R8
  ingress_excluded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> !lk_mask_o[$past(lk_port_i)]);
  // R5
  drop_empty_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_o && !lk_accept_o) |-> (lk_mask_o == '0));
  // R9
  miss_no_untag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_o && !lk_hit_o) |-> (lk_untag_o == '0));
endmodule

bind vlan_resolve vlan_resolve_chk #(.N_PORT(N_PORT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_req_i(lk_req_i), .lk_port_i(lk_port_i),
  .lk_valid_o(lk_valid_o), .lk_hit_o(lk_hit_o), .lk_accept_o(lk_accept_o),
  .lk_mask_o(lk_mask_o), .lk_untag_o(lk_untag_o)
);

// File: tb/vlan_resolve_tb_top.sv
module vlan_resolve_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 32;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 0, wr_kind = 0, wr_valid = 0, wr_discard = 0, wr_verify = 0;
  logic [4:0] wr_idx = '0;
  logic [11:0] wr_vid = '0, lk_vid = '0;
  logic [3:0] wr_member = '0, wr_untag = '0, dflt = '0;
  logic lk_req = 0;
  logic [1:0] lk_port = '0;
  logic lk_valid, lk_hit, lk_accept;
  logic [3:0] lk_mask, lk_untag;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlan_resolve dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_kind_i(wr_kind),
    .wr_idx_i(wr_idx), .wr_vid_i(wr_vid), .wr_valid_i(wr_valid),
    .wr_member_i(wr_member), .wr_untag_i(wr_untag), .wr_discard_i(wr_discard),
    .wr_verify_i(wr_verify), .lk_req_i(lk_req), .lk_port_i(lk_port),
    .lk_vid_i(lk_vid), .dflt_flood_i(dflt), .lk_valid_o(lk_valid),
    .lk_hit_o(lk_hit), .lk_accept_o(lk_accept), .lk_mask_o(lk_mask),
    .lk_untag_o(lk_untag)
  );

  // bench copy of the table
  bit        m_valid [NE];
  int        m_vid   [NE];
  bit [3:0]  m_mem   [NE];
  bit [3:0]  m_ut    [NE];
  bit [3:0]  m_disc, m_ver;

  int n_chk = 0, n_fail = 0;
  bit pend = 0, done = 0;
  bit e_hit, e_acc;
  bit [3:0] e_mask, e_ut;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic predict(int port, int vid, bit [3:0] fl);
    int idx = -1;
    bit mem;
    for (int i = NE - 1; i >= 0; i--)
      if (m_valid[i] && m_vid[i] != 0 && m_vid[i] == vid) idx = i; // R3 R4
    e_hit = (idx >= 0);
    mem   = e_hit && m_mem[idx][port];
    e_acc = !(m_disc[port] && !mem);                                // R5
    if (!e_acc)            e_mask = 4'b0;
    else if (m_ver[port])  e_mask = e_hit ? m_mem[idx] : 4'b0;      // R6
    else                   e_mask = fl;                              // R7
    e_mask[port] = 1'b0;                                            // R8
    e_ut = e_hit ? (m_ut[idx] & m_mem[idx]) : 4'b0;                 // R9
  endtask

  task automatic step(bit we, bit kind, int idx, int vid, bit v, int mem, int ut,
                      bit dis, bit ver, bit lk, int port, int lvid, int fl);
    @(negedge clk);
    if (pend) begin
      chk("R2 valid", lk_valid, 1);
      chk("R3 hit", lk_hit, e_hit);
      chk("R5 accept", lk_accept, e_acc);
      chk("R6 R7 R8 mask", lk_mask, e_mask);
      chk("R9 untag", lk_untag, e_ut);
    end else chk("R2 idle valid", lk_valid, 0);
    wr_en = we; wr_kind = kind; wr_idx = 5'(idx); wr_vid = 12'(vid);
    wr_valid = v; wr_member = 4'(mem); wr_untag = 4'(ut);
    wr_discard = dis; wr_verify = ver;
    lk_req = lk; lk_port = 2'(port); lk_vid = 12'(lvid); dflt = 4'(fl);
    pend = lk;
    if (lk) predict(port, lvid, 4'(fl)); // table as before this cycle's write (R1)
    if (we && !kind) begin
      m_valid[idx] = v; m_vid[idx] = vid; m_mem[idx] = 4'(mem); m_ut[idx] = 4'(ut);
    end else if (we && kind && idx < NP) begin
      m_disc[idx] = dis; m_ver[idx] = ver;
    end
  endtask

  task automatic wr_ent(int idx, int vid, bit v, int mem, int ut);
    step(1, 0, idx, vid, v, mem, ut, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr_port(int p, bit dis, bit ver);
    step(1, 1, p, 0, 0, 0, 0, dis, ver, 0, 0, 0, 0);
  endtask
  task automatic look(int port, int vid, int fl);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, port, vid, fl);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NE; i++) begin m_valid[i] = 0; m_vid[i] = 0; m_mem[i] = 0; m_ut[i] = 0; end
    m_disc = 0; m_ver = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid", lk_valid, 0);
    chk("R10 mask", lk_mask, 0);
    chk("R10 untag", lk_untag, 0);
    rst_ni = 1'b1;
    look(1, 5, 4'hf);          // R10 empty table: miss, default flood
    look(0, 0, 4'h6);          // R3 VID 0 never matches
    // directed table
    wr_ent(3, 10, 1, 4'b0110, 4'b0100);
    wr_ent(1, 10, 1, 4'b1001, 4'b1111);   // R4 lower index shares VID
    wr_ent(5, 0, 1, 4'b1111, 4'b1111);    // R3 VID 0 valid entry
    wr_ent(6, 20, 0, 4'b1111, 4'b0000);   // R3 invalid entry
    wr_ent(9, 30, 1, 4'b1110, 4'b0010);
    look(0, 10, 4'hf);         // R4 entry 1 wins
    look(0, 0, 4'hf);
    look(2, 20, 4'hb);
    wr_port(1, 1, 0);          // R5 discard on port 1
    wr_port(2, 0, 1);          // R6 verify on port 2
    look(1, 10, 4'hf);         // member of entry 1: not member -> drop
    look(1, 30, 4'hf);         // member -> accept, default flood
    look(1, 77, 4'hf);         // R5 miss with discard -> drop
    look(2, 30, 4'h5);         // R6 membership mask
    look(2, 77, 4'hf);         // R6 miss with verify -> empty
    look(3, 77, 4'h9);         // R7 default flood
    // R1 same-cycle write and lookup sees old, next cycle sees new
    step(1, 0, 1, 11, 1, 4'b0011, 4'b0001, 0, 0, 1, 3, 10, 4'hf);
    look(3, 10, 4'hf);
    look(3, 11, 4'hf);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // random mix
    for (int n = 0; n < 2000; n++) begin
      int r = int'($urandom_range(0, 99));
      bit we = (r < 30);
      bit kind = (r < 6);
      step(we, kind, kind ? int'($urandom_range(0, 3)) : int'($urandom_range(0, 31)),
           int'($urandom_range(0, 7)), bit'($urandom_range(0, 3) != 0),
           int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 8)), int'($urandom_range(0, 15)));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule